// File: doc/BRIEF.md
# Mixed-Granularity Address Translation Buffer

This block is a fully associative translation buffer that turns 32-bit virtual addresses into physical addresses. Every slot carries its own size code, so 1 MB segments, 8 KB large pages and 4 KB small pages sit side by side in one array. A slot compares only the virtual address bits above its own region boundary. The bits below that boundary pass straight through into the physical address. Each slot also stores a bufferable bit (B) and a cacheable bit (C), and these come back with every hit.

A lookup presented in one cycle returns its answer on the next. New translations arrive on a refill port, and a round-robin pointer chooses the slot that receives each one. Two maintenance commands remove mappings: flush-all clears every slot, and flush-one clears the slots that match a given address. An instance for the instruction side can have flush-one switched off by a parameter.

Control is a small decoded command state per cycle (`OP_IDLE`, `OP_REFILL`, `OP_FLUSH_ONE`, `OP_FLUSH_ALL`). The command is chosen by priority: flush-all first, then flush-one, then refill. The response state register holds `RS_NONE` (no lookup in the previous cycle), `RS_MISS` or `RS_HIT`. On every edge the response state moves to `RS_NONE` if `lk_req` is low, to `RS_HIT` if `lk_req` is high and some valid slot matches, and to `RS_MISS` otherwise.

Top module: `mpsz_tlb`

## Requirements
- R1: After reset every slot is invalid, the round-robin pointer is 0 (the first refill goes to slot 0), and `lk_hit` and `lk_pa`, `lk_b`, `lk_c` are 0.
- R2: A lookup sampled with `lk_req` high at edge N gives its result on the outputs after edge N. `lk_hit` is 1 only if a valid slot matched. With no request or on a miss, `lk_hit`, `lk_pa`, `lk_b` and `lk_c` are all 0.
- R3: Size code 0 (1 MB) compares virtual address bits [31:20], and `lk_pa` = {stored pa[31:20], va[19:0]}.
- R4: Size code 1 (8 KB) compares bits [31:13], and `lk_pa` = {stored pa[31:13], va[12:0]}.
- R5: Size code 2 (4 KB) compares bits [31:12], and `lk_pa` = {stored pa[31:12], va[11:0]}. Size code 3 behaves exactly like code 2.
- R6: On a hit, `lk_b` and `lk_c` equal the B and C bits written by that slot's refill.
- R7: An accepted refill writes the slot at the pointer, and the pointer then advances by one, wrapping from NUM_ENT-1 to 0. After NUM_ENT+1 refills the first one has been overwritten. Flushes leave the pointer unchanged.
- R8: When a refill and a lookup happen in the same cycle, the lookup sees the contents from before the refill.
- R9: Flush-all invalidates every slot. A flush-one or refill in the same cycle is ignored, so the pointer does not move.
- R10: Flush-one invalidates every slot whose own-size compare matches `fl_va` and leaves the other slots valid. A refill in the same cycle is ignored.
- R11: With EN_FLUSH_ONE = 0, `fl_one` has no effect, and a refill in the same cycle is accepted.
- R12: When several valid slots match one lookup, the slot with the lowest index supplies pa, B and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| rf_we | input | 1 | Refill write |
| rf_va | input | 32 | Refill virtual address |
| rf_pa | input | 32 | Refill physical address |
| rf_size | input | 2 | Refill size: 0 = 1 MB, 1 = 8 KB, 2/3 = 4 KB |
| rf_b | input | 1 | Refill bufferable bit |
| rf_c | input | 1 | Refill cacheable bit |
| fl_all | input | 1 | Invalidate all slots |
| fl_one | input | 1 | Invalidate slots matching `fl_va` |
| fl_va | input | 32 | Address for flush-one |
| lk_hit | output | 1 | Lookup hit (one cycle after request) |
| lk_pa | output | 32 | Translated physical address |
| lk_b | output | 1 | Bufferable bit of the hit slot |
| lk_c | output | 1 | Cacheable bit of the hit slot |

## Verification
The internal state is visible at the ports one cycle after any lookup. A valid bit or tag that is wrong shows up as a wrong `lk_hit` on the first lookup of that address. A pointer that is wrong, or that advances wrongly, stays hidden until the array wraps. Then the wrong translation survives, and the fault shows on the next lookup of the evicted address. For that reason the bench fills the array past its depth and compares every cycle against a behavioural model, and the checker also watches the pointer and the valid vector directly.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int SEG_LSB = 20;
    localparam int LPG_LSB = 13;
    localparam int SPG_LSB = 12;

    typedef enum logic [1:0] {
        SZ_SEG = 2'd0,
        SZ_LPG = 2'd1,
        SZ_SPG = 2'd2,
        SZ_RSV = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_REFILL,
        OP_FLUSH_ONE,
        OP_FLUSH_ALL
    } tlb_op_e;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_MISS,
        RS_HIT
    } rsp_st_e;

    typedef struct packed {
        logic            vld;
        pg_size_e        size;
        logic [VA_W-1:0] vtag;
        logic [VA_W-1:0] pbase;
        logic            b;
        logic            c;
    } tlb_ent_t;

    function automatic logic [VA_W-1:0] size_mask(pg_size_e s);
        logic [VA_W-1:0] ones;
        ones = '1;
        unique case (s)
            SZ_SEG:         return ones << SEG_LSB;
            SZ_LPG:         return ones << LPG_LSB;
            SZ_SPG, SZ_RSV: return ones << SPG_LSB;
            default:        return ones << SPG_LSB;
        endcase
    endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
    import tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  tlb_ent_t        wr_ent,
    input  logic            inv_all,
    input  logic            inv_one_en,
    input  logic [VA_W-1:0] fl_va,
    input  logic [VA_W-1:0] lk_va,
    output tlb_ent_t        ent_q,
    output logic            lk_match
);
    logic [VA_W-1:0] own_mask;
    logic            fl_match;

    always_comb begin
        own_mask = size_mask(ent_q.size);
        lk_match = ent_q.vld && ((lk_va & own_mask) == ent_q.vtag);
        fl_match = ent_q.vld && ((fl_va & own_mask) == ent_q.vtag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else if (inv_all || (inv_one_en && fl_match)) begin
            ent_q.vld <= 1'b0;
        end else if (wr_en) begin
            ent_q <= wr_ent;
        end
    end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
    parameter int NUM_ENT = 32,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + IDX_W'(1);
        end
    end
endmodule

// File: rtl/tlb_hit_sel.sv
module tlb_hit_sel #(
    parameter int NUM_ENT = 32
) (
    input  logic [NUM_ENT-1:0] match,
    output logic [NUM_ENT-1:0] grant,
    output logic               any
);
    always_comb begin
        grant = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
        any = |match;
    end
endmodule

// File: rtl/mpsz_tlb.sv
module mpsz_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENT      = 32,
    parameter bit EN_FLUSH_ONE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_req,
    input  logic [31:0] lk_va,
    input  logic        rf_we,
    input  logic [31:0] rf_va,
    input  logic [31:0] rf_pa,
    input  logic [1:0]  rf_size,
    input  logic        rf_b,
    input  logic        rf_c,
    input  logic        fl_all,
    input  logic        fl_one,
    input  logic [31:0] fl_va,
    output logic        lk_hit,
    output logic [31:0] lk_pa,
    output logic        lk_b,
    output logic        lk_c
);
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    tlb_op_e          op;
    logic             inv_all, inv_one_en, rf_go;
    logic [IDX_W-1:0] rr_ptr;
    tlb_ent_t         wr_ent;
    tlb_ent_t         ents [NUM_ENT];
    logic [NUM_ENT-1:0] match_vec, grant, vld_vec;
    logic             any_hit;
    logic [31:0]      sel_pa;
    logic             sel_b, sel_c;
    rsp_st_e          rs_q, rs_nxt;
    logic [31:0]      pa_q;
    logic             b_q, c_q;

    // command decode: flush-all > flush-one > refill
    always_comb begin
        if (fl_all)                     op = OP_FLUSH_ALL;
        else if (fl_one && EN_FLUSH_ONE) op = OP_FLUSH_ONE;
        else if (rf_we)                 op = OP_REFILL;
        else                            op = OP_IDLE;
    end

    always_comb begin
        inv_all    = 1'b0;
        inv_one_en = 1'b0;
        rf_go      = 1'b0;
        unique case (op)
            OP_IDLE:      ;
            OP_REFILL:    rf_go      = 1'b1;
            OP_FLUSH_ONE: inv_one_en = 1'b1;
            OP_FLUSH_ALL: inv_all    = 1'b1;
            default:      ;
        endcase
    end

    always_comb begin
        logic [31:0] m;
        m            = size_mask(pg_size_e'(rf_size));
        wr_ent.vld   = 1'b1;
        wr_ent.size  = pg_size_e'(rf_size);
        wr_ent.vtag  = rf_va & m;
        wr_ent.pbase = rf_pa & m;
        wr_ent.b     = rf_b;
        wr_ent.c     = rf_c;
    end

    tlb_rr_ptr #(.NUM_ENT(NUM_ENT)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rf_go),
        .ptr   (rr_ptr)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        tlb_entry u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (rf_go && (rr_ptr == IDX_W'(g))),
            .wr_ent     (wr_ent),
            .inv_all    (inv_all),
            .inv_one_en (inv_one_en),
            .fl_va      (fl_va),
            .lk_va      (lk_va),
            .ent_q      (ents[g]),
            .lk_match   (match_vec[g])
        );
        assign vld_vec[g] = ents[g].vld;
    end

    tlb_hit_sel #(.NUM_ENT(NUM_ENT)) u_sel (
        .match (match_vec),
        .grant (grant),
        .any   (any_hit)
    );

    always_comb begin
        logic [31:0] m;
        sel_pa = '0;
        sel_b  = 1'b0;
        sel_c  = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            m = size_mask(ents[i].size);
            if (grant[i]) begin
                sel_pa = (ents[i].pbase & m) | (lk_va & ~m);
                sel_b  = ents[i].b;
                sel_c  = ents[i].c;
            end
        end
    end

    always_comb begin
        if (!lk_req)      rs_nxt = RS_NONE;
        else if (any_hit) rs_nxt = RS_HIT;
        else              rs_nxt = RS_MISS;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= RS_NONE;
            pa_q <= '0;
            b_q  <= 1'b0;
            c_q  <= 1'b0;
        end else begin
            rs_q <= rs_nxt;
            pa_q <= sel_pa;
            b_q  <= sel_b;
            c_q  <= sel_c;
        end
    end

    // outputs
    always_comb begin
        lk_hit = 1'b0;
        lk_pa  = '0;
        lk_b   = 1'b0;
        lk_c   = 1'b0;
        unique case (rs_q)
            RS_NONE, RS_MISS: ;
            RS_HIT: begin
                lk_hit = 1'b1;
                lk_pa  = pa_q;
                lk_b   = b_q;
                lk_c   = c_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int NUM_ENT      = 32,
    parameter bit EN_FLUSH_ONE = 1'b1,
    localparam int IDX_W       = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic               lk_hit,
    input logic [31:0]        lk_pa,
    input logic               lk_b,
    input logic               lk_c,
    input logic               rf_we,
    input logic               fl_all,
    input logic               fl_one,
    input logic [IDX_W-1:0]   ptr,
    input logic [NUM_ENT-1:0] vld_vec,
    input logic [NUM_ENT-1:0] grant
);
    logic rf_acc;
    logic [IDX_W-1:0] ptr_next;
    assign rf_acc   = rf_we && !fl_all && !(fl_one && EN_FLUSH_ONE);
    assign ptr_next = (ptr == IDX_W'(NUM_ENT - 1)) ? '0 : ptr + IDX_W'(1);

    a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $past(lk_req));

    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == 32'd0 && !lk_b && !lk_c));

    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rf_acc |=> (ptr == $past(ptr_next)));

    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_acc |=> $stable(ptr));

    a_r9_flush_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> (vld_vec == '0));

    a_r12_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

bind mpsz_tlb tlb_chk #(.NUM_ENT(NUM_ENT), .EN_FLUSH_ONE(EN_FLUSH_ONE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_req  (lk_req),
    .lk_hit  (lk_hit),
    .lk_pa   (lk_pa),
    .lk_b    (lk_b),
    .lk_c    (lk_c),
    .rf_we   (rf_we),
    .fl_all  (fl_all),
    .fl_one  (fl_one),
    .ptr     (rr_ptr),
    .vld_vec (vld_vec),
    .grant   (grant)
);

// File: tb/sim_mpsz_tlb.sv
module sim_mpsz_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 0, rf_we = 0, rf_b = 0, rf_c = 0, fl_all = 0, fl_one = 0;
    logic [31:0] lk_va = 0, rf_va = 0, rf_pa = 0, fl_va = 0;
    logic [1:0] rf_size = 0;
    logic h0, h1, b0, b1, c0, c1;
    logic [31:0] pa0, pa1;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // model state per instance: 0 = flush-one enabled, 1 = disabled
    bit          m_vld [2][N];
    logic [31:0] m_tag [2][N];
    logic [31:0] m_pb  [2][N];
    int          m_sz  [2][N];
    bit          m_b   [2][N];
    bit          m_c   [2][N];
    int          m_ptr [2];

    bit          exp_on;
    bit          e_hit [2];
    logic [31:0] e_pa  [2];
    bit          e_b   [2];
    bit          e_c   [2];
    string       e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpsz_tlb #(.NUM_ENT(N), .EN_FLUSH_ONE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
        .rf_we(rf_we), .rf_va(rf_va), .rf_pa(rf_pa), .rf_size(rf_size),
        .rf_b(rf_b), .rf_c(rf_c), .fl_all(fl_all), .fl_one(fl_one), .fl_va(fl_va),
        .lk_hit(h0), .lk_pa(pa0), .lk_b(b0), .lk_c(c0));

    mpsz_tlb #(.NUM_ENT(N), .EN_FLUSH_ONE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
        .rf_we(rf_we), .rf_va(rf_va), .rf_pa(rf_pa), .rf_size(rf_size),
        .rf_b(rf_b), .rf_c(rf_c), .fl_all(fl_all), .fl_one(fl_one), .fl_va(fl_va),
        .lk_hit(h1), .lk_pa(pa1), .lk_b(b1), .lk_c(c1));

    function automatic logic [31:0] region_mask(int sz);
        if (sz == 0)      return 32'hFFF0_0000;
        else if (sz == 1) return 32'hFFFF_E000;
        else              return 32'hFFFF_F000;
    endfunction

    task automatic check_inst(int m, logic ah, logic [31:0] ap, logic ab, logic ac);
        checks++;
        if (ah !== e_hit[m] || ap !== e_pa[m] || ab !== e_b[m] || ac !== e_c[m]) begin
            errors++;
            $display("FAIL %s u%0d: act hit=%0b pa=%h b=%0b c=%0b exp hit=%0b pa=%h b=%0b c=%0b",
                     e_tag, m, ah, ap, ab, ac, e_hit[m], e_pa[m], e_b[m], e_c[m]);
        end
    endtask

    task automatic compare_prev();
        if (exp_on) begin
            check_inst(0, h0, pa0, b0, c0);
            check_inst(1, h1, pa1, b1, c1);
        end
    endtask

    task automatic model_apply(bit req, logic [31:0] va, bit we, logic [31:0] rva,
                               logic [31:0] rpa, int rsz, bit rb, bit rc,
                               bit fa, bit fo, logic [31:0] fva);
        for (int m = 0; m < 2; m++) begin
            e_hit[m] = 0; e_pa[m] = 0; e_b[m] = 0; e_c[m] = 0;
            if (req) begin
                for (int i = 0; i < N; i++) begin
                    if (!e_hit[m] && m_vld[m][i] &&
                        ((va & region_mask(m_sz[m][i])) == m_tag[m][i])) begin
                        e_hit[m] = 1;
                        e_pa[m]  = m_pb[m][i] | (va & ~region_mask(m_sz[m][i]));
                        e_b[m]   = m_b[m][i];
                        e_c[m]   = m_c[m][i];
                    end
                end
            end
            if (fa) begin
                for (int i = 0; i < N; i++) m_vld[m][i] = 0;
            end else if (fo && m == 0) begin
                for (int i = 0; i < N; i++)
                    if ((fva & region_mask(m_sz[m][i])) == m_tag[m][i]) m_vld[m][i] = 0;
            end else if (we) begin
                int p = m_ptr[m];
                m_vld[m][p] = 1;
                m_sz[m][p]  = (rsz == 3) ? 2 : rsz;
                m_tag[m][p] = rva & region_mask(rsz);
                m_pb[m][p]  = rpa & region_mask(rsz);
                m_b[m][p]   = rb;
                m_c[m][p]   = rc;
                m_ptr[m]    = (p + 1) % N;
            end
        end
    endtask

    // one clock: check previous result, drive new inputs, predict
    task automatic cyc(string tag, bit req, logic [31:0] va,
                       bit we = 0, logic [31:0] rva = 0, logic [31:0] rpa = 0,
                       int rsz = 0, bit rb = 0, bit rc = 0,
                       bit fa = 0, bit fo = 0, logic [31:0] fva = 0);
        compare_prev();
        lk_req = req; lk_va = va; rf_we = we; rf_va = rva; rf_pa = rpa;
        rf_size = rsz[1:0]; rf_b = rb; rf_c = rc; fl_all = fa; fl_one = fo; fl_va = fva;
        model_apply(req, va, we, rva, rpa, rsz, rb, rc, fa, fo, fva);
        e_tag  = tag;
        exp_on = 1;
        @(posedge clk);
        #1;
    endtask

    task automatic refill(string tag, logic [31:0] rva, logic [31:0] rpa, int rsz, bit rb, bit rc);
        cyc(tag, 0, 0, 1, rva, rpa, rsz, rb, rc);
    endtask

    task automatic look(string tag, logic [31:0] va);
        cyc(tag, 1, va);
    endtask

    task automatic finish_run();
        compare_prev();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: act cycles=%0d exp below 20000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        for (int m = 0; m < 2; m++) begin
            m_ptr[m] = 0;
            for (int i = 0; i < N; i++) begin
                m_vld[m][i] = 0; m_tag[m][i] = 0; m_pb[m][i] = 0;
                m_sz[m][i] = 0; m_b[m][i] = 0; m_c[m][i] = 0;
            end
        end
        exp_on = 0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state at the ports
        checks++;
        if (h0 !== 0 || pa0 !== 0 || h1 !== 0 || pa1 !== 0) begin
            errors++;
            $display("FAIL R1: act hit=%0b/%0b pa=%h exp hit=0 pa=0", h0, h1, pa0);
        end
        look("R1", 32'h1234_5678);
        look("R1", 32'h0000_0000);

        // R3 1 MB segment
        refill("R3", 32'h1230_0000, 32'hABC0_0000, 0, 1, 0);
        look("R3 R6", 32'h1234_5678);
        look("R3", 32'h1240_0000);
        look("R2", 32'h1230_0000);
        cyc("R2", 0, 32'h1230_0000);
        // R4 8 KB page
        refill("R4", 32'h0000_4000, 32'h8000_2000, 1, 0, 1);
        look("R4 R6", 32'h0000_5ABC);
        look("R4", 32'h0000_6000);
        // R5 4 KB page and reserved code
        refill("R5", 32'h4000_1000, 32'h9000_5000, 2, 1, 1);
        look("R5", 32'h4000_1FFF);
        look("R5", 32'h4000_2000);
        refill("R5", 32'h5000_3000, 32'h6000_7000, 3, 0, 0);
        look("R5", 32'h5000_3123);
        look("R5", 32'h5000_2123);
        // R8 refill and lookup together
        cyc("R8", 1, 32'h7000_0010, 1, 32'h7000_0000, 32'h0110_0000, 0, 1, 1);
        look("R8", 32'h7000_0010);
        // R12 overlapping slot, lowest index wins
        refill("R12", 32'h1230_0000, 32'h1111_1000, 2, 0, 1);
        look("R12", 32'h1230_0ABC);
        // R10 R11 flush-one
        cyc("R10 R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4000_1000);
        look("R10 R11", 32'h4000_1234);
        look("R10", 32'h0000_5000);
        cyc("R10 R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h1230_0000);
        look("R10 R11", 32'h1230_0ABC);
        cyc("R10 R11", 0, 0, 1, 32'h2200_0000, 32'h3300_0000, 0, 0, 1, 0, 1, 32'h0);
        look("R10 R11", 32'h2200_0044);
        // R9 flush-all beats refill
        cyc("R9", 0, 0, 1, 32'h2500_0000, 32'h3500_0000, 0, 1, 0, 1, 0, 0);
        look("R9", 32'h2500_0000);
        look("R9", 32'h0000_5ABC);
        look("R9", 32'h7000_0010);
        // R7 wrap-around eviction
        for (int i = 0; i <= N; i++)
            refill("R7", 32'h0800_0000 + (i << 12), 32'h0C00_0000 + (i << 12), 2, i[0], i[1]);
        for (int i = 0; i <= N; i++)
            look("R7", 32'h0800_0000 + (i << 12) + 32'h44);
        // R2 mixed traffic
        for (int k = 0; k < 800; k++) begin
            int sel = $urandom_range(0, 19);
            logic [31:0] hi = {$urandom_range(0, 3), 28'h0} | (32'($urandom_range(0, 3)) << 20);
            logic [31:0] lo = 32'($urandom_range(0, 32'h3FFF));
            if (sel == 0)
                cyc("R9", $urandom_range(0, 1), hi | lo, 0, 0, 0, 0, 0, 0, 1);
            else if (sel <= 2)
                cyc("R10", $urandom_range(0, 1), hi | lo, $urandom_range(0, 1), hi, lo << 16,
                    $urandom_range(0, 3), 0, 1, 0, 1, hi | lo);
            else if (sel <= 7)
                cyc("R7", $urandom_range(0, 1), hi | lo, 1, hi | (lo ^ 32'h1000),
                    32'($urandom), $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1));
            else
                look("R2", hi | lo);
        end
        finish_run();
    end
endmodule